// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns a logical address into a physical one using a small on-chip table of segments. The upper bits of the logical address pick a table entry and the lower bits are the offset inside that segment. Each entry holds a physical base, a limit, three access-right bits and a present flag. The offset is compared with the limit and the access kind with the rights. When both checks pass, the base is added to the offset to give the physical address. The result, or one fault flag, appears one clock after the request.

The table is loaded through a write port that only takes effect while the privileged-mode input is high. Each segment is one contiguous physical region, so moving a segment only means rewriting its base. Faults are ranked so that exactly one is reported for a failing request: a missing segment first, then an out-of-range offset, then a rights violation.

Top module: `seg_xlate`

## Requirements
- R1: After reset every entry is marked not present, and all outputs are zero until the first request.
- R2: The segment number is the top SEG_BITS bits of `acc_addr` and the offset is the low OFF_BITS bits. For an accepted request the physical address is base + offset, wrapped to PA_BITS bits, and it appears with `out_valid` on the clock edge after the one that samples `acc_valid`.
- R3: The limit is the highest legal offset. An offset greater than the limit raises `out_bound_fault`, and an offset equal to the limit is accepted.
- R4: The `acc_type` codes are 00 read, 01 write and 10 execute. They are checked against rights bit 0 (read), bit 1 (write) and bit 2 (execute). A missing right raises `out_prot_fault`, and code 11 always raises it.
- R5: A request to an entry whose present flag is 0 raises `out_seg_fault`.
- R6: At most one fault flag is high at a time. A segment fault wins over a bound fault, and a bound fault wins over a protection fault.
- R7: A table write takes effect only when `wr_en` and `priv` are both high. A write with `priv` low leaves the table unchanged.
- R8: When any fault flag is high, `out_paddr` is zero.
- R9: A request in the same cycle as a write to its entry uses the old contents. The new contents apply from the next request on.
- R10: On a cycle after a clock edge that saw no request, `out_valid`, `out_paddr` and all fault flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| priv | input | 1 | Privileged mode; enables table writes |
| wr_en | input | 1 | Table write strobe |
| wr_seg | input | SEG_BITS | Entry to write |
| wr_base | input | PA_BITS | Physical base of the segment |
| wr_limit | input | OFF_BITS | Highest legal offset |
| wr_rwx | input | 3 | Rights: bit0 read, bit1 write, bit2 execute |
| wr_present | input | 1 | Present flag |
| acc_valid | input | 1 | Translation request |
| acc_addr | input | SEG_BITS+OFF_BITS | Logical address {segment, offset} |
| acc_type | input | 2 | 00 read, 01 write, 10 execute, 11 reserved |
| out_valid | output | 1 | Result valid |
| out_paddr | output | PA_BITS | Physical address, zero on fault |
| out_seg_fault | output | 1 | Segment not present |
| out_bound_fault | output | 1 | Offset above limit |
| out_prot_fault | output | 1 | Access kind not permitted |

## Verification
The assertions check the following on every cycle:
- fault exclusivity and zero address on any fault;
- quiet outputs after an idle edge and the one-cycle response timing;
- a bound fault only when the sampled offset exceeded the selected limit;
- an unchanged table after any write attempted outside privileged mode.

Only the bench scenarios can show the arithmetic of base plus offset, including wrap-around. The same applies to the exact limit boundary, the mapping of each access code to its right, and the read-before-write order of a request colliding with a write to the same entry.

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int SEG_BITS = 3,
  parameter int OFF_BITS = 12,
  parameter int PA_BITS  = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         priv,
  input  logic                         wr_en,
  input  logic [SEG_BITS-1:0]          wr_seg,
  input  logic [PA_BITS-1:0]           wr_base,
  input  logic [OFF_BITS-1:0]          wr_limit,
  input  logic [2:0]                   wr_rwx,
  input  logic                         wr_present,
  input  logic                         acc_valid,
  input  logic [SEG_BITS+OFF_BITS-1:0] acc_addr,
  input  logic [1:0]                   acc_type,
  output logic                         out_valid,
  output logic [PA_BITS-1:0]           out_paddr,
  output logic                         out_seg_fault,
  output logic                         out_bound_fault,
  output logic                         out_prot_fault
);
  localparam int NSEG = 1 << SEG_BITS;
  localparam int LA_BITS = SEG_BITS + OFF_BITS;

  logic [NSEG-1:0][PA_BITS-1:0]  base_q;
  logic [NSEG-1:0][OFF_BITS-1:0] lim_q;
  logic [NSEG-1:0][2:0]          rwx_q;
  logic [NSEG-1:0]               pres_q;

  wire wr_ok = wr_en & priv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      lim_q  <= '0;
      rwx_q  <= '0;
      pres_q <= '0;
    end else if (wr_ok) begin
      base_q[wr_seg] <= wr_base;
      lim_q[wr_seg]  <= wr_limit;
      rwx_q[wr_seg]  <= wr_rwx;
      pres_q[wr_seg] <= wr_present;
    end
  end

  wire [SEG_BITS-1:0] seg = acc_addr[LA_BITS-1:OFF_BITS];
  wire [OFF_BITS-1:0] off = acc_addr[OFF_BITS-1:0];
  wire [2:0]          rights = rwx_q[seg];

  logic allowed;
  always_comb begin
    case (acc_type)
      2'b00:   allowed = rights[0];
      2'b01:   allowed = rights[1];
      2'b10:   allowed = rights[2];
      default: allowed = 1'b0;
    endcase
  end

  wire missing = !pres_q[seg];
  wire over    = off > lim_q[seg];
  wire sf      = missing;
  wire bf      = !missing && over;
  wire pf      = !missing && !over && !allowed;
  wire [PA_BITS-1:0] sum = base_q[seg] + PA_BITS'(off);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid       <= 1'b0;
      out_paddr       <= '0;
      out_seg_fault   <= 1'b0;
      out_bound_fault <= 1'b0;
      out_prot_fault  <= 1'b0;
    end else begin
      out_valid       <= acc_valid;
      out_seg_fault   <= acc_valid && sf;
      out_bound_fault <= acc_valid && bf;
      out_prot_fault  <= acc_valid && pf;
      out_paddr       <= (acc_valid && !(sf || bf || pf)) ? sum : '0;
    end
  end

  // R6
  fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_seg_fault, out_bound_fault, out_prot_fault}));

  // R8
  fault_zero_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_seg_fault || out_bound_fault || out_prot_fault) |-> out_paddr == '0);

  // R2
  resp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> out_valid);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> (!out_valid && out_paddr == '0 && !out_seg_fault &&
                    !out_bound_fault && !out_prot_fault));

  // R3
  bound_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !missing && !over) |=> !out_bound_fault);

  // R7
  user_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !priv) |=> (base_q == $past(base_q) && lim_q == $past(lim_q) &&
                          rwx_q == $past(rwx_q) && pres_q == $past(pres_q)));
endmodule

// File: tb/tb_seg_xlate.sv
module tb_seg_xlate;
  localparam int SB = 3, OB = 12, PB = 16;

  logic clk = 0, rst_n = 0, priv = 0, wr_en = 0, wr_present = 0, acc_valid = 0;
  logic [SB-1:0] wr_seg = '0;
  logic [PB-1:0] wr_base = '0;
  logic [OB-1:0] wr_limit = '0;
  logic [2:0] wr_rwx = '0;
  logic [SB+OB-1:0] acc_addr = '0;
  logic [1:0] acc_type = '0;
  logic out_valid, out_seg_fault, out_bound_fault, out_prot_fault;
  logic [PB-1:0] out_paddr;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  seg_xlate #(.SEG_BITS(SB), .OFF_BITS(OB), .PA_BITS(PB)) dut (.*);

  task automatic expect_out(string tag, logic v, logic [PB-1:0] pa, logic sf, logic bf, logic pf);
    tests++;
    if (out_valid !== v || out_paddr !== pa || out_seg_fault !== sf ||
        out_bound_fault !== bf || out_prot_fault !== pf) begin
      fails++;
      $display("FAIL %s: got v=%0b pa=%h s=%0b b=%0b p=%0b, exp v=%0b pa=%h s=%0b b=%0b p=%0b",
               tag, out_valid, out_paddr, out_seg_fault, out_bound_fault, out_prot_fault,
               v, pa, sf, bf, pf);
    end
  endtask

  task automatic load(bit p, int s, logic [PB-1:0] b, logic [OB-1:0] l, logic [2:0] r, bit pr);
    @(negedge clk);
    priv = p; wr_en = 1; wr_seg = SB'(s); wr_base = b; wr_limit = l; wr_rwx = r; wr_present = pr;
    @(negedge clk);
    wr_en = 0; priv = 0;
  endtask

  task automatic access(string tag, int s, int o, logic [1:0] t,
                        logic [PB-1:0] pa, logic sf, logic bf, logic pf);
    @(negedge clk);
    acc_valid = 1; acc_addr = {SB'(s), OB'(o)}; acc_type = t;
    @(negedge clk);
    acc_valid = 0;
    expect_out(tag, 1, pa, sf, bf, pf);
  endtask

  task automatic t_reset;
    @(negedge clk);
    expect_out("R1 idle after reset", 0, 0, 0, 0, 0);
    access("R1 R5 entry absent after reset", 0, 5, 2'b00, 0, 1, 0, 0);
    @(negedge clk);
    expect_out("R10 quiet after idle edge", 0, 0, 0, 0, 0);
  endtask

  task automatic t_basic;
    load(1, 2, 16'h4000, 12'h0FF, 3'b011, 1);
    access("R2 read translates", 2, 'h010, 2'b00, 16'h4010, 0, 0, 0);
    access("R3 offset equal to limit", 2, 'h0FF, 2'b01, 16'h40FF, 0, 0, 0);
    access("R3 offset above limit", 2, 'h100, 2'b00, 0, 0, 1, 0);
    access("R4 execute denied", 2, 'h020, 2'b10, 0, 0, 0, 1);
    access("R4 reserved code", 2, 'h020, 2'b11, 0, 0, 0, 1);
  endtask

  task automatic t_rights;
    load(1, 4, 16'h1000, 12'hFFF, 3'b100, 1);
    access("R4 execute-only read denied", 4, 'h0, 2'b00, 0, 0, 0, 1);
    access("R4 execute-only write denied", 4, 'h0, 2'b01, 0, 0, 0, 1);
    access("R4 execute allowed", 4, 'h123, 2'b10, 16'h1123, 0, 0, 0);
  endtask

  task automatic t_prio;
    access("R6 bound beats protection", 2, 'h200, 2'b10, 0, 0, 1, 0);
    load(1, 6, 16'h2000, 12'h00F, 3'b000, 0);
    access("R6 R8 segment beats bound", 6, 'hFFF, 2'b11, 0, 1, 0, 0);
  endtask

  task automatic t_priv;
    load(0, 5, 16'h3000, 12'hFFF, 3'b111, 1);
    access("R7 user write left entry absent", 5, 'h1, 2'b00, 0, 1, 0, 0);
    load(0, 2, 16'h0000, 12'hFFF, 3'b111, 1);
    access("R7 user write kept old base", 2, 'h001, 2'b00, 16'h4001, 0, 0, 0);
  endtask

  task automatic t_wrap;
    load(1, 7, 16'hFF80, 12'hFFF, 3'b111, 1);
    access("R2 address wraps", 7, 'h100, 2'b01, 16'h0080, 0, 0, 0);
  endtask

  task automatic t_collide;
    @(negedge clk);
    priv = 1; wr_en = 1; wr_seg = 3; wr_base = 16'h5000; wr_limit = 12'hFFF;
    wr_rwx = 3'b001; wr_present = 1;
    acc_valid = 1; acc_addr = {3'd3, 12'h004}; acc_type = 2'b00;
    @(negedge clk);
    wr_en = 0; priv = 0; acc_valid = 0;
    expect_out("R9 colliding request sees old entry", 1, 0, 1, 0, 0);
    access("R9 next request sees new entry", 3, 'h004, 2'b00, 16'h5004, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_basic();
    t_rights();
    t_prio();
    t_priv();
    t_wrap();
    t_collide();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule